// File: doc/BRIEF.md
# Split-Space Internal Data Memory Decoder

This block is the on-chip scratch memory of a small 8-bit controller, together with the steering logic that decides where each data access lands. It stores 256 bytes. The lower 128 addresses always hold RAM. The upper 128 addresses are shared with a register space that lives outside the block, on a separate register bus.

Which one an upper address selects depends only on the addressing mode of the access. An access in direct mode to an address with bit 7 set leaves the RAM alone and goes out on the register bus as a one-cycle request. An access in indirect mode always lands in RAM, across the full 00h–FFh range. Indirect 90h and direct 90h therefore name two different storage places.

Reads come back registered, one cycle after the read strobe. Register-bus read data is sampled in the cycle of the request.

Top module: `iram_split_dec`

## Requirements
- R1: A direct-mode (`ind_mode`=0) write to an address 00h–7Fh stores `wr_data` in RAM on the rising edge. A later direct read of that address presents the stored byte on `rd_data` after the next rising edge.
- R2: A direct-mode access with `addr[7]`=1 drives `reg_req`=1 in the same cycle as the strobe, with `reg_addr`=`addr`, `reg_we`=`wr_en` and `reg_wdata`=`wr_data`. A direct write of this kind does not change RAM.
- R3: An indirect-mode (`ind_mode`=1) access to any address 00h–FFh reads or writes RAM and never raises `reg_req`.
- R4: Indirect address 90h and direct address 90h select different storage. Writing one leaves the value read through the other unchanged.
- R5: A direct read with `addr[7]`=1 returns, on `rd_data` after the next rising edge, the `reg_rdata` value present in the request cycle. The RAM contents play no part in that result.
- R6: `reg_req` is low in every cycle with no strobe, and in every cycle whose access goes to RAM.
- R7: `rd_data` holds its value in every cycle that follows a cycle without a read strobe.
- R8: While `rst_n` is low, and after it is released, `rd_data` is 00h and `reg_req` is 0 until the first access. Reset does not clear the RAM contents.
- R9: `rd_en` and `wr_en` high in the same cycle is an illegal input. The design flags it, and the stimulus never produces it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Access address |
| ind_mode | input | 1 | 1 = indirect access, 0 = direct access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| reg_req | output | 1 | Register-bus request, high for the access cycle |
| reg_we | output | 1 | Register-bus write (1) or read (0) |
| reg_addr | output | 8 | Register-bus address |
| reg_wdata | output | 8 | Register-bus write data |
| reg_rdata | input | 8 | Register-bus read data, valid in the request cycle |

## Verification
The bench first fills all 256 RAM bytes through indirect writes. It then aims at the aliased upper half.

- A direct write to 90h must not alter the indirect 90h byte. A decoder that ignored the mode would corrupt RAM there.
- A direct read of an upper address must return the register-bus value and not the RAM byte. A mux wired the wrong way would hand back stale RAM.
- An indirect upper access must keep `reg_req` low. A decoder that looked only at bit 7 would send spurious bus cycles.
- Idle cycles follow reads. A read register without an enable would let `rd_data` drift.

// File: rtl/iram_pkg.sv
package iram_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_RAM  = 2'd1,
    ROUTE_REG  = 2'd2
  } route_e;
endpackage

// File: rtl/iram_steer.sv
module iram_steer
  import iram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              ind_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ram_rd,
  output logic              ram_we,
  output logic              reg_req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              rd_from_reg
);
  localparam int SPLIT_BIT = ADDR_W - 1;

  route_e route;
  logic   any_strobe;

  always_comb begin
    any_strobe = rd_en | wr_en;
    if (!any_strobe)
      route = ROUTE_NONE;
    else if (!ind_mode && addr[SPLIT_BIT])
      route = ROUTE_REG;
    else
      route = ROUTE_RAM;
  end

  always_comb begin
    ram_rd      = (route == ROUTE_RAM) & rd_en;
    ram_we      = (route == ROUTE_RAM) & wr_en;
    reg_req     = (route == ROUTE_REG);
    reg_we      = (route == ROUTE_REG) & wr_en;
    reg_addr    = addr;
    reg_wdata   = wr_data;
    rd_from_reg = (route == ROUTE_REG) & rd_en;
  end
endmodule

// File: rtl/iram_array.sv
module iram_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rd,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = rdata;
    if (rd)
      rdata_d = mem[addr];
  end

  always_ff @(posedge clk) begin
    if (we)
      mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= rdata_d;
  end
endmodule

// File: rtl/iram_rmux.sv
module iram_rmux #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_rd,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] ram_q,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] rd_data
);
  logic              src_reg_q, src_reg_d;
  logic [DATA_W-1:0] reg_q, reg_d;

  always_comb begin
    src_reg_d = src_reg_q;
    reg_d     = reg_q;
    if (reg_rd) begin
      src_reg_d = 1'b1;
      reg_d     = reg_rdata;
    end else if (ram_rd) begin
      src_reg_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_reg_q <= 1'b1;
      reg_q     <= '0;
    end else begin
      src_reg_q <= src_reg_d;
      reg_q     <= reg_d;
    end
  end

  assign rd_data = src_reg_q ? reg_q : ram_q;

  // R5: a register-bus read returns the bus data of the request cycle
  a_r5_reg_read_data: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (rd_data == $past(reg_rdata)));
endmodule

// File: rtl/iram_split_dec.sv
module iram_split_dec #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ind_mode,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              reg_req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic              ram_rd, ram_we, rd_from_reg;
  logic [DATA_W-1:0] ram_q;

  iram_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_steer (
    .ind_mode    (ind_mode),
    .addr        (addr),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .ram_rd      (ram_rd),
    .ram_we      (ram_we),
    .reg_req     (reg_req),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .rd_from_reg (rd_from_reg)
  );

  iram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .rd    (ram_rd),
    .we    (ram_we),
    .addr  (addr),
    .wdata (wr_data),
    .rdata (ram_q)
  );

  iram_rmux #(.DATA_W(DATA_W)) u_rmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .ram_rd    (ram_rd),
    .reg_rd    (rd_from_reg),
    .ram_q     (ram_q),
    .reg_rdata (reg_rdata),
    .rd_data   (rd_data)
  );

  // R9: simultaneous read and write strobes are illegal
  a_r9_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  // R3: indirect accesses never reach the register bus
  a_r3_indirect_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    ind_mode |-> !reg_req);

  // R2: a register-bus cycle never writes RAM
  a_r2_req_excludes_ram: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> !ram_we);

  // R6: no strobe, no register request
  a_r6_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |-> !reg_req);

  // R7: read data holds when the previous cycle had no read
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/iram_split_dec_bench.sv
module iram_split_dec_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr;
  logic       ind_mode, rd_en, wr_en;
  logic [7:0] wr_data, rd_data, reg_addr, reg_wdata, reg_rdata;
  logic       reg_req, reg_we;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [7:0] model [256];
  logic [7:0] exp_rd;

  always #10 clk = ~clk;

  iram_split_dec u_iram_split_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ind_mode(ind_mode),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input logic ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      summary();
      $finish;
    end
  end

  // one access: drive at negedge, check bus side, then check rd_data after edge
  task automatic op(input logic ind, input logic rd, input logic wr,
                    input logic [7:0] a, input logic [7:0] d, input string tag);
    logic to_reg;
    logic [7:0] bus_val;
    @(negedge clk);
    ind_mode = ind; rd_en = rd; wr_en = wr; addr = a; wr_data = d;
    bus_val = a ^ 8'hC3 ^ 8'(cyc);
    reg_rdata = bus_val;
    to_reg = !ind && a[7] && (rd || wr);
    #1;
    chk(!(rd && wr), {tag, " R9 stimulus"}, {7'd0, rd & wr}, 8'h00);
    chk(reg_req == to_reg, {tag, " R6 reg_req"}, {7'd0, reg_req}, {7'd0, to_reg});
    if (to_reg) begin
      chk(reg_addr == a, {tag, " R2 reg_addr"}, reg_addr, a);
      chk(reg_we == wr, {tag, " R2 reg_we"}, {7'd0, reg_we}, {7'd0, wr});
      if (wr) chk(reg_wdata == d, {tag, " R2 reg_wdata"}, reg_wdata, d);
    end
    @(posedge clk);
    if (wr && !to_reg) model[a] = d;
    if (rd) exp_rd = to_reg ? bus_val : model[a];
    #2;
    chk(rd_data == exp_rd, {tag, " rd_data"}, rd_data, exp_rd);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; ind_mode = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    wr_data = '0; reg_rdata = '0; exp_rd = 8'h00;
    repeat (3) @(posedge clk);
    #2;
    chk(rd_data == 8'h00, "R8 reset rd_data", rd_data, 8'h00);
    chk(reg_req == 1'b0, "R8 reset reg_req", {7'd0, reg_req}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk(rd_data == 8'h00, "R8 post-reset rd_data", rd_data, 8'h00);

    // fill every byte through indirect writes
    for (int i = 0; i < 256; i++) op(1, 0, 1, 8'(i), 8'(i * 7 + 3), "R3 fill");
    for (int i = 0; i < 256; i++) op(1, 1, 0, 8'(i), 8'h00, "R3 ind read");
    // direct lower half
    for (int i = 0; i < 128; i++) op(0, 1, 0, 8'(i), 8'h00, "R1 dir read");
    for (int i = 0; i < 128; i += 9) op(0, 0, 1, 8'(i), 8'(~i), "R1 dir write");
    for (int i = 0; i < 128; i += 9) op(0, 1, 0, 8'(i), 8'h00, "R1 dir readback");
    // aliasing at 90h
    op(0, 0, 1, 8'h90, 8'hEE, "R2 dir write 90h");
    op(1, 1, 0, 8'h90, 8'h00, "R4 ind 90h after dir write");
    op(0, 1, 0, 8'h90, 8'h00, "R5 dir read 90h");
    op(1, 0, 1, 8'h90, 8'h11, "R4 ind write 90h");
    op(0, 1, 0, 8'h90, 8'h00, "R4 dir read 90h after ind write");
    op(1, 1, 0, 8'h90, 8'h00, "R4 ind readback 90h");
    // every upper address, direct write then indirect read: RAM untouched
    for (int i = 128; i < 256; i++) op(0, 0, 1, 8'(i), 8'h5A, "R2 dir upper write");
    for (int i = 128; i < 256; i++) op(1, 1, 0, 8'(i), 8'h00, "R2 RAM untouched");
    for (int i = 128; i < 256; i += 5) op(0, 1, 0, 8'(i), 8'h00, "R5 dir upper read");
    // hold after reads
    op(1, 1, 0, 8'h42, 8'h00, "R7 setup");
    for (int i = 0; i < 6; i++) op(0, 0, 0, 8'(i * 40), 8'h00, "R7 idle hold");
    op(0, 1, 0, 8'hF0, 8'h00, "R7 setup reg");
    for (int i = 0; i < 4; i++) op(1, 0, 0, 8'hF0, 8'h00, "R7 idle hold reg");
    summary();
    $finish;
  end
endmodule